// File: doc/BRIEF.md
# Clock Controller Register Bank

This block is the software-visible configuration store of a chip's clock control unit. A host reaches it through a plain 32-bit register port: a select strobe, a write flag, a byte address, write data and registered read data. The bank keeps the PLL control words, the CPU/AXI and peripheral-bus divider words, the DRAM configuration word, the memory-bus reset word, two PLL settle-time words and the PLL bias and tuning words. Each one comes out of reset at a fixed value.

No analog behaviour is modelled. A PLL reports lock as soon as software enables it. The DRAM update request bit is cleared at once, so a poll on it ends at the first read. Accesses at or above byte offset 0x308, and accesses that are not word aligned, are bad accesses. Such a read returns zero, such a write is dropped, and an error flag goes high for one cycle. Every other in-range word acts as a plain 32-bit storage location that starts at zero.

Top module: `ccr_bank`

## Requirements
- R1: After reset the PLL control words read as follows. 0x000 and 0x020 read 0x00001000. 0x008 reads 0x00035514. 0x010, 0x018, 0x038 and 0x048 read 0x03006207. 0x028 and 0x044 read 0x00041811.
- R2: After reset the other defined words read as follows. 0x050 reads 0x00010000, 0x054 reads 0x00001010, 0x058 reads 0x01000000, 0x0F4 reads 0, 0x0FC reads 0x80000000, and 0x200 and 0x204 read 0x000000FF. Of the bias words, 0x220 reads 0x08100200, 0x230 reads 0x81104000, 0x234 and 0x244 read 0x10100010, and 0x224, 0x228, 0x22C, 0x23C and 0x248 read 0x10100000. Of the tuning words, 0x250 reads 0x0A101000 and 0x260 reads 0x14880000.
- R3: Every other aligned word below 0x308 reads 0 after reset and stores all 32 bits written to it.
- R4: A write to one of the nine PLL control words with bit 31 set stores bit 28 as 1. With bit 31 clear, bit 28 is stored exactly as written. All other bits are stored as written.
- R5: A write to the DRAM configuration word at 0x0F4 stores bit 16 as 0, so that bit always reads 0. All other bits are stored as written.
- R6: A read at byte offset 0x308 or above returns 0 and raises the error output for exactly one cycle.
- R7: A write at byte offset 0x308 or above changes no word and raises the error output for exactly one cycle.
- R8: An access with address bits [1:0] not zero raises the error output for one cycle. Such a write changes no word, and such a read returns 0.
- R9: Read data updates on the clock edge that samples a read select. It holds its value through idle cycles and write cycles.
- R10: The error output stays low after good accesses and while idle.
- R11: The divider, memory-bus, settle-time, bias and tuning words store all 32 written bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Access strobe, one access per cycle in which it is high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after a read select |
| err | output | 1 | One-cycle pulse after a bad access |

## Verification
A stuck, aliased or wrongly reset word shows up only when that word is read back. The data then appears one cycle after the read select, so the bench keeps a full model of the word array and compares every read against it. A wrong decode of a PLL or DRAM word shows as a bit-28 or bit-16 mismatch on the first read after the write. A bad out-of-range or unaligned decode shows in two places: on the error flag on the very next cycle, and later as a changed aliased word, which the bench catches by reading back the word that an out-of-range address would truncate to.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int LIMIT     = 'h308;
    localparam int NUM_WORDS = LIMIT / 4;
    localparam int IDX_W     = $clog2(NUM_WORDS);

    localparam int PLL_EN_BIT   = 31;
    localparam int PLL_LOCK_BIT = 28;
    localparam int DRAM_UPD_BIT = 16;
    localparam int DRAM_IDX     = 'h0F4 / 4;

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_PLL   = 2'd1,
        K_DRAM  = 2'd2
    } kind_e;

    typedef struct packed {
        logic             we;
        logic             re;
        logic             bad;
        logic [IDX_W-1:0] idx;
        kind_e            kind;
    } acc_t;

    function automatic logic is_pll(input int unsigned idx);
        case (idx)
            0, 2, 4, 6, 8, 10, 14, 17, 18: return 1'b1;
            default:                       return 1'b0;
        endcase
    endfunction

    function automatic kind_e word_kind(input int unsigned idx);
        if (is_pll(idx))       return K_PLL;
        if (idx == DRAM_IDX)   return K_DRAM;
        return K_PLAIN;
    endfunction

    function automatic logic [DATA_W-1:0] reset_word(input int unsigned idx);
        case (idx)
            0, 8:                  return 32'h0000_1000;
            2:                     return 32'h0003_5514;
            4, 6, 14, 18:          return 32'h0300_6207;
            10, 17:                return 32'h0004_1811;
            20:                    return 32'h0001_0000;
            21:                    return 32'h0000_1010;
            22:                    return 32'h0100_0000;
            63:                    return 32'h8000_0000;
            128, 129:              return 32'h0000_00FF;
            136:                   return 32'h0810_0200;
            140:                   return 32'h8110_4000;
            141, 145:              return 32'h1010_0010;
            137, 138, 139, 143, 146: return 32'h1010_0000;
            148:                   return 32'h0A10_1000;
            152:                   return 32'h1488_0000;
            default:               return '0;
        endcase
    endfunction

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
    import ccr_pkg::*;
#(
    parameter int A_W   = ADDR_W,
    parameter int LIM   = LIMIT
) (
    input  logic           sel,
    input  logic           wr,
    input  logic [A_W-1:0] addr,
    output acc_t           acc
);
    logic aligned;
    logic in_range;

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        in_range = (32'(addr) < LIM);
        acc.bad  = sel && !(aligned && in_range);
        acc.we   = sel && wr && !acc.bad;
        acc.re   = sel && !wr;
        acc.idx  = addr[IDX_W+1:2];
        acc.kind = word_kind(int'(addr[IDX_W+1:2]));
    end
endmodule

// File: rtl/ccr_wfilter.sv
module ccr_wfilter
    import ccr_pkg::*;
#(
    parameter int D_W = DATA_W
) (
    input  kind_e          kind,
    input  logic [D_W-1:0] din,
    output logic [D_W-1:0] dout
);
    always_comb begin
        dout = din;
        unique case (kind)
            K_PLL:   if (din[PLL_EN_BIT]) dout[PLL_LOCK_BIT] = 1'b1;
            K_DRAM:  dout[DRAM_UPD_BIT] = 1'b0;
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/ccr_store.sv
module ccr_store
    import ccr_pkg::*;
#(
    parameter int D_W   = DATA_W,
    parameter int WORDS = NUM_WORDS,
    parameter int I_W   = IDX_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [I_W-1:0] widx,
    input  logic [D_W-1:0] wd,
    input  logic [I_W-1:0] ridx,
    output logic [D_W-1:0] rd
);
    logic [D_W-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++)
                words[i] <= reset_word(i);
        end else if (we && (32'(widx) < WORDS)) begin
            words[widx] <= wd;
        end
    end

    always_comb begin
        rd = '0;
        if (32'(ridx) < WORDS)
            rd = words[ridx];
    end
endmodule

// File: rtl/ccr_bank.sv
module ccr_bank
    import ccr_pkg::*;
#(
    parameter int A_W = ADDR_W,
    parameter int D_W = DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sel,
    input  logic           wr,
    input  logic [A_W-1:0] addr,
    input  logic [D_W-1:0] wdata,
    output logic [D_W-1:0] rdata,
    output logic           err
);
    acc_t           acc;
    logic [D_W-1:0] wd_f;
    logic [D_W-1:0] rd_w;

    ccr_decode #(.A_W(A_W), .LIM(LIMIT)) u_dec (
        .sel  (sel),
        .wr   (wr),
        .addr (addr),
        .acc  (acc)
    );

    ccr_wfilter #(.D_W(D_W)) u_filt (
        .kind (acc.kind),
        .din  (wdata),
        .dout (wd_f)
    );

    ccr_store #(.D_W(D_W), .WORDS(NUM_WORDS), .I_W(IDX_W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .we   (acc.we),
        .widx (acc.idx),
        .wd   (wd_f),
        .ridx (acc.idx),
        .rd   (rd_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            err <= acc.bad;
            if (acc.re)
                rdata <= acc.bad ? '0 : rd_w;
        end
    end
endmodule

// File: rtl/ccr_bank_chk.sv
module ccr_bank_chk
    import ccr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sel,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              err
);
    logic oob, unal, bad_acc, rd_pll, rd_dram;

    always_comb begin
        oob     = (32'(addr) >= LIMIT);
        unal    = (addr[1:0] != 2'b00);
        bad_acc = sel && (oob || unal);
        rd_pll  = sel && !wr && !oob && !unal && is_pll(int'(addr[ADDR_W-1:2]));
        rd_dram = sel && !wr && (32'(addr) == 'h0F4);
    end

    // R6, R7, R8: bad access gives an error pulse next cycle
    p_err_on_bad_r6: assert property (@(posedge clk) disable iff (rst)
        bad_acc |=> err);
    // R10: no error without a bad access
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !bad_acc |=> !err);
    // R6: out-of-range read returns zero
    p_oob_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr && oob) |=> (rdata == '0));
    // R8: unaligned read returns zero
    p_unal_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr && unal) |=> (rdata == '0));
    // R9: read data holds unless a read is selected
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(sel && !wr) |=> $stable(rdata));
    // R4: an enabled PLL never reads back unlocked
    p_pll_lock_r4: assert property (@(posedge clk) disable iff (rst)
        rd_pll |=> !(rdata[PLL_EN_BIT] && !rdata[PLL_LOCK_BIT]));
    // R5: DRAM update request always reads zero
    p_dram_upd_r5: assert property (@(posedge clk) disable iff (rst)
        rd_dram |=> !rdata[DRAM_UPD_BIT]);
endmodule

bind ccr_bank ccr_bank_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .sel   (sel),
    .wr    (wr),
    .addr  (addr),
    .rdata (rdata),
    .err   (err)
);

// File: tb/sim_ccr_bank.sv
`timescale 1ns/1ps
module sim_ccr_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        wr  = 1'b0;
    logic [11:0] addr  = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] mdl [194];

    always #2 clk = ~clk;

    ccr_bank u0 (
        .clk(clk), .rst(rst), .sel(sel), .wr(wr),
        .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
    );

    function automatic logic [31:0] exp_reset(input int i);
        case (i)
            0, 8:                    return 32'h0000_1000;
            2:                       return 32'h0003_5514;
            4, 6, 14, 18:            return 32'h0300_6207;
            10, 17:                  return 32'h0004_1811;
            20:                      return 32'h0001_0000;
            21:                      return 32'h0000_1010;
            22:                      return 32'h0100_0000;
            63:                      return 32'h8000_0000;
            128, 129:                return 32'h0000_00FF;
            136:                     return 32'h0810_0200;
            140:                     return 32'h8110_4000;
            141, 145:                return 32'h1010_0010;
            137, 138, 139, 143, 146: return 32'h1010_0000;
            148:                     return 32'h0A10_1000;
            152:                     return 32'h1488_0000;
            default:                 return 32'h0;
        endcase
    endfunction

    function automatic bit pll_word(input int i);
        return (i == 0 || i == 2 || i == 4 || i == 6 || i == 8 ||
                i == 10 || i == 14 || i == 17 || i == 18);
    endfunction

    function automatic logic [31:0] stored(input int i, input logic [31:0] d);
        logic [31:0] v = d;
        if (pll_word(i) && d[31]) v[28] = 1'b1;
        if (i == 61) v[16] = 1'b0;
        return v;
    endfunction

    function automatic string req_of(input int i);
        if (pll_word(i))          return "R4";
        if (i == 61)              return "R5";
        if (exp_reset(i) != 0 || i == 61) return "R11";
        return "R3";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic e);
        @(negedge clk);
        sel = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        rd = rdata; e = err;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] rd;
        logic        e;
        logic [31:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset values: R1 R2 R3, plus err low R10
        chk("R10", {31'd0, err}, 32'd0);
        chk("R9", rdata, 32'd0);
        for (int i = 0; i < 194; i++) begin
            mdl[i] = exp_reset(i);
            access(1'b0, 12'(i * 4), 32'd0, rd, e);
            chk(pll_word(i) ? "R1" : ((mdl[i] != 0 || i == 61) ? "R2" : "R3"), rd, mdl[i]);
        end

        // R4 directed
        access(1'b1, 12'h010, 32'h8000_0001, rd, e);
        access(1'b0, 12'h010, 32'd0, rd, e);
        chk("R4", rd, 32'h9000_0001);
        access(1'b1, 12'h044, 32'h1000_0005, rd, e);
        access(1'b0, 12'h044, 32'd0, rd, e);
        chk("R4", rd, 32'h1000_0005);
        access(1'b1, 12'h044, 32'h0000_0005, rd, e);
        access(1'b0, 12'h044, 32'd0, rd, e);
        chk("R4", rd, 32'h0000_0005);
        mdl[4] = 32'h9000_0001; mdl[17] = 32'h0000_0005;

        // R5 directed
        access(1'b1, 12'h0F4, 32'hFFFF_FFFF, rd, e);
        access(1'b0, 12'h0F4, 32'd0, rd, e);
        chk("R5", rd, 32'hFFFE_FFFF);
        mdl[61] = 32'hFFFE_FFFF;

        // R11 directed
        access(1'b1, 12'h050, 32'hDEAD_BEEF, rd, e);
        access(1'b0, 12'h050, 32'd0, rd, e);
        chk("R11", rd, 32'hDEAD_BEEF);
        mdl[20] = 32'hDEAD_BEEF;

        // R6 out-of-range reads
        access(1'b0, 12'h308, 32'd0, rd, e);
        chk("R6", rd, 32'd0);
        chk("R6", {31'd0, e}, 32'd1);
        @(negedge clk);
        chk("R6", {31'd0, err}, 32'd0);
        access(1'b0, 12'hFFC, 32'd0, rd, e);
        chk("R6", rd, 32'd0);

        // R7 out-of-range write aliasing onto word 0
        access(1'b1, 12'h400, 32'h1234_5678, rd, e);
        chk("R7", {31'd0, e}, 32'd1);
        @(negedge clk);
        chk("R7", {31'd0, err}, 32'd0);
        access(1'b0, 12'h000, 32'd0, rd, e);
        chk("R7", rd, mdl[0]);

        // R8 unaligned
        access(1'b1, 12'h102, 32'hCAFE_F00D, rd, e);
        chk("R8", {31'd0, e}, 32'd1);
        access(1'b0, 12'h100, 32'd0, rd, e);
        chk("R8", rd, mdl[64]);
        access(1'b0, 12'h201, 32'd0, rd, e);
        chk("R8", rd, 32'd0);
        chk("R8", {31'd0, e}, 32'd1);

        // R9 hold through idle and writes
        access(1'b0, 12'h200, 32'd0, rd, e);
        held = rd;
        repeat (3) @(negedge clk);
        chk("R9", rdata, held);
        access(1'b1, 12'h300, 32'h5555_AAAA, rd, e);
        chk("R9", rd, held);
        mdl[192] = 32'h5555_AAAA;

        // random mix
        for (int n = 0; n < 800; n++) begin
            int unsigned pick = $urandom_range(0, 9);
            logic        w    = 1'($urandom_range(0, 1));
            logic [31:0] d    = $urandom();
            logic [11:0] a;
            bit          bad;
            int          idx;
            if (pick < 3)       a = 12'(4 * $urandom_range(0, 24));
            else if (pick < 7)  a = 12'(4 * $urandom_range(0, 193));
            else if (pick < 8)  a = 12'($urandom_range('h308, 'hFFF)) & 12'hFFC;
            else if (pick < 9)  a = 12'(4 * $urandom_range(0, 193)) | 12'($urandom_range(1, 3));
            else                a = 12'h0F4;
            bad = (a >= 12'h308) || (a[1:0] != 2'b00);
            idx = int'(a[11:2]);
            access(w, a, d, rd, e);
            chk(bad ? (a[1:0] != 0 ? "R8" : (w ? "R7" : "R6")) : "R10",
                {31'd0, e}, {31'd0, bad});
            if (w && !bad) mdl[idx] = stored(idx, d);
            if (!w) chk(bad ? (a[1:0] != 0 ? "R8" : "R6") : req_of(idx),
                        rd, bad ? 32'd0 : mdl[idx]);
        end

        // final sweep: no stray writes anywhere (R7 R8)
        for (int i = 0; i < 194; i++) begin
            access(1'b0, 12'(i * 4), 32'd0, rd, e);
            chk("R7", rd, mdl[i]);
        end

        finish_run();
    end
endmodule